// File: doc/BRIEF.md
# Register-Coupled Data Memory

This block gives a small processor a word-addressed scratch store that is reached through two dedicated registers. A memory address register, loaded from the processor data bus, selects one of 2048 sixteen-bit words. A memory data register supplies the word to be stored and captures the word that is read. Because the storage array answers combinationally from the address, a read or a write finishes in one clock cycle.

The data register has two sources. When its bus-load strobe is high it takes the processor bus value. When the strobe is low it takes the memory read data. It updates when either the bus-load strobe or the read enable is high, and it keeps its value otherwise. All strobes are plain single-cycle control pins with no handshake. The instruction decoder asserts them, and the block accepts every strobe on the cycle it is seen. No back-pressure exists.

Top module: `dmem_core`

## Requirements
- R1: While `rst_n` is low, and on the first sampled edge after it rises, `addr_q` and `data_q` read 0.
- R2: On an edge with `ld_addr` high, `addr_q` takes `bus_data`. With `ld_addr` low, `addr_q` keeps its value.
- R3: On an edge with `ld_data` high, `data_q` takes `bus_data`.
- R4: On an edge with `rd_en` high and `ld_data` low, `data_q` takes the word stored at index `addr_q[10:0]`.
- R5: When `ld_data` and `rd_en` are both high, `data_q` takes `bus_data` and ignores the memory word.
- R6: On an edge with both `ld_data` and `rd_en` low, `data_q` keeps its value.
- R7: On an edge with `wr_en` high, the word at index `addr_q[10:0]` becomes `data_q`. A later read of that index returns it.
- R8: Only `addr_q[10:0]` selects a word. Addresses that differ only in bits 15:11 reach the same word.
- R9: When `wr_en` and `rd_en` are high in the same cycle, `data_q` captures the contents the word held before that edge.
- R10: `wr_en` changes neither `addr_q` nor `data_q`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset of both registers |
| bus_data | input | 16 | Processor data bus value |
| ld_addr | input | 1 | Load the address register from the bus |
| ld_data | input | 1 | Load the data register from the bus; selects the bus source |
| rd_en | input | 1 | Capture the addressed memory word into the data register |
| wr_en | input | 1 | Store the data register into the addressed word |
| addr_q | output | 16 | Address register contents |
| data_q | output | 16 | Data register contents |

## Verification
An internal fault shows on `data_q` within one edge of the read that exposes it. A wrong write index, a lost write, or a wrong alias surfaces on the first later read of the affected word. A wrong source choice or a wrong enable is visible on the edge right after the strobe. An address register that ignores or invents loads shows directly on `addr_q` one edge later. Random traffic over a small aliased address set keeps write-then-read gaps short, so stored-word faults show within a few dozen cycles.

// File: rtl/dmem_pkg.sv
package dmem_pkg;
  localparam int unsigned WORD_W  = 16;
  localparam int unsigned INDEX_W = 11;
  typedef logic [WORD_W-1:0] word_t;
  typedef enum logic [1:0] {SRC_HOLD, SRC_MEM, SRC_BUS} dsrc_e;
endpackage

// File: rtl/dmem_array.sv
module dmem_array #(
  parameter int unsigned W  = 16,
  parameter int unsigned IW = 11
) (
  input  logic          clk,
  input  logic          we,
  input  logic [IW-1:0] idx,
  input  logic [W-1:0]  wdata,
  output logic [W-1:0]  rdata
);
  localparam int unsigned DEPTH = 1 << IW;
  logic [W-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (we) cells[idx] <= wdata;
  end

  assign rdata = cells[idx];
endmodule

// File: rtl/dmem_addr_reg.sv
module dmem_addr_reg #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] din,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (!rst_n)    q <= '0;
    else if (load) q <= din;
  end

  p_addr_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> q == $past(din));
  p_addr_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(q));
endmodule

// File: rtl/dmem_data_reg.sv
module dmem_data_reg
  import dmem_pkg::*;
#(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         bus_ld,
  input  logic         rd_en,
  input  logic [W-1:0] bus_in,
  input  logic [W-1:0] mem_in,
  output logic [W-1:0] q
);
  dsrc_e        src;
  logic [W-1:0] nxt;

  always_comb begin
    if (bus_ld)     src = SRC_BUS;
    else if (rd_en) src = SRC_MEM;
    else            src = SRC_HOLD;
  end

  always_comb begin
    unique case (src)
      SRC_BUS: nxt = bus_in;
      SRC_MEM: nxt = mem_in;
      default: nxt = q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) q <= '0;
    else        q <= nxt;
  end

  p_bus_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
    bus_ld |=> q == $past(bus_in));
  p_mem_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !bus_ld) |=> q == $past(mem_in));
  p_bus_priority_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && bus_ld) |=> q == $past(bus_in));
  p_data_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_en && !bus_ld) |=> $stable(q));
endmodule

// File: rtl/dmem_core.sv
module dmem_core
  import dmem_pkg::*;
#(
  parameter int unsigned W  = WORD_W,
  parameter int unsigned IW = INDEX_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] bus_data,
  input  logic         ld_addr,
  input  logic         ld_data,
  input  logic         rd_en,
  input  logic         wr_en,
  output logic [W-1:0] addr_q,
  output logic [W-1:0] data_q
);
  logic [W-1:0]  rd_word;
  logic [IW-1:0] idx;

  assign idx = addr_q[IW-1:0];

  dmem_addr_reg #(.W(W)) u_areg (
    .clk(clk), .rst_n(rst_n), .load(ld_addr), .din(bus_data), .q(addr_q)
  );

  dmem_data_reg #(.W(W)) u_dreg (
    .clk(clk), .rst_n(rst_n), .bus_ld(ld_data), .rd_en(rd_en),
    .bus_in(bus_data), .mem_in(rd_word), .q(data_q)
  );

  dmem_array #(.W(W), .IW(IW)) u_mem (
    .clk(clk), .we(wr_en), .idx(idx), .wdata(data_q), .rdata(rd_word)
  );

  p_write_keeps_regs_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !ld_addr && !ld_data && !rd_en) |=> ($stable(addr_q) && $stable(data_q)));
  p_reset_clear_r1: assert property (@(posedge clk)
    !rst_n |=> (addr_q == '0 && data_q == '0));
endmodule

// File: tb/sim_dmem_core.sv
module sim_dmem_core;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] bus_data = '0;
  logic        ld_addr = 1'b0, ld_data = 1'b0, rd_en = 1'b0, wr_en = 1'b0;
  logic [15:0] addr_q, data_q;

  int checks = 0;
  int failures = 0;

  logic [15:0] m_addr, m_data;
  logic [15:0] m_mem [2048];

  always #10 clk = ~clk;

  dmem_core u0 (
    .clk(clk), .rst_n(rst_n), .bus_data(bus_data), .ld_addr(ld_addr),
    .ld_data(ld_data), .rd_en(rd_en), .wr_en(wr_en),
    .addr_q(addr_q), .data_q(data_q)
  );

  function automatic logic [15:0] exp_data(logic bl, logic rd, logic [15:0] bus,
                                           logic [15:0] cur, logic [15:0] word);
    if (bl)      return bus;
    else if (rd) return word;
    else         return cur;
  endfunction

  task automatic check(string req, logic [15:0] got, logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic step(string req, logic la, logic ld, logic rd, logic wr, logic [15:0] bus);
    logic [15:0] word;
    @(negedge clk);
    ld_addr = la; ld_data = ld; rd_en = rd; wr_en = wr; bus_data = bus;
    word = m_mem[m_addr[10:0]];
    @(posedge clk);
    if (wr) m_mem[m_addr[10:0]] = m_data;
    m_data = exp_data(ld, rd, bus, m_data, word);
    if (la) m_addr = bus;
    #1;
    check({req, " addr"}, addr_q, m_addr);
    check({req, " data"}, data_q, m_data);
  endtask

  initial begin
    #(20 * 150000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'd7321));
    m_addr = '0; m_data = '0;
    repeat (3) @(posedge clk);
    #1;
    check("R1 reset addr", addr_q, 16'h0000);
    check("R1 reset data", data_q, 16'h0000);
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #1;
    check("R1 post addr", addr_q, 16'h0000);
    check("R1 post data", data_q, 16'h0000);

    // fill indices 0..31 with known words
    for (int i = 0; i < 32; i++) begin
      step("R2", 1'b1, 1'b0, 1'b0, 1'b0, 16'(i));
      step("R3", 1'b0, 1'b1, 1'b0, 1'b0, 16'hA500 ^ 16'(i * 37));
      step("R7 R10", 1'b0, 1'b0, 1'b0, 1'b1, 16'hDEAD);
    end
    // R4 read back after clobbering data register
    step("R2", 1'b1, 1'b0, 1'b0, 1'b0, 16'd5);
    step("R3", 1'b0, 1'b1, 1'b0, 1'b0, 16'h0000);
    step("R4", 1'b0, 1'b0, 1'b1, 1'b0, 16'hFFFF);
    check("R4 direct", data_q, 16'hA500 ^ 16'(5 * 37));
    // R8 alias: 0x0805 reaches index 5
    step("R8", 1'b1, 1'b0, 1'b0, 1'b0, 16'h0805);
    step("R8", 1'b0, 1'b1, 1'b0, 1'b0, 16'h1234);
    step("R8", 1'b0, 1'b0, 1'b0, 1'b1, 16'h0000);
    step("R8", 1'b1, 1'b0, 1'b0, 1'b0, 16'hF805);
    step("R8", 1'b0, 1'b1, 1'b0, 1'b0, 16'h0000);
    step("R8", 1'b0, 1'b0, 1'b1, 1'b0, 16'h0000);
    check("R8 alias", data_q, 16'h1234);
    // R9 same-cycle read and write: old contents captured
    step("R9", 1'b0, 1'b1, 1'b0, 1'b0, 16'hBEEF);
    step("R9", 1'b0, 1'b0, 1'b1, 1'b1, 16'h0000);
    check("R9 old", data_q, 16'h1234);
    step("R9", 1'b0, 1'b0, 1'b1, 1'b0, 16'h0000);
    check("R9 new", data_q, 16'hBEEF);
    // R5 priority, R6 hold
    step("R5", 1'b0, 1'b1, 1'b1, 1'b0, 16'h5A5A);
    check("R5 bus wins", data_q, 16'h5A5A);
    step("R6", 1'b0, 1'b0, 1'b0, 1'b0, 16'h9999);
    check("R6 hold", data_q, 16'h5A5A);
    // R10 write leaves registers alone
    step("R10", 1'b0, 1'b0, 1'b0, 1'b1, 16'h7777);
    check("R10 data", data_q, 16'h5A5A);
    check("R10 addr", addr_q, 16'hF805);

    // constrained random over known indices 0..31 with random high bits
    for (int n = 0; n < 3000; n++) begin
      logic [15:0] bus;
      logic [3:0]  r;
      r = 4'($urandom);
      bus = 16'($urandom);
      if (r[0]) bus = {bus[15:11], 6'd0, bus[4:0]};
      step("RND R2-R7", r[0], r[1], r[2], r[3], bus);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule